// File: doc/BRIEF.md
# Load-Switch Gate Protection Controller

This block decides, once per clock, whether one channel of a protected high-side load switch may conduct. It takes an active-low enable, an undervoltage indication, a reverse-voltage indication, a current-limit-active indication from the analog regulation loop, an 8-bit die temperature in degrees Celsius and a one-millisecond tick pulse. It drives a switch-on output and a 3-bit state code.

A current limit that persists after the switch has turned on starts an on/off duty cycle. The switch stays in a short regulated-on window, then turns off for a long cool-down window, and the cycle repeats until the limit clears or the enable is toggled. Undervoltage forces a re-arm delay that starts once the supply has recovered. Two thermal comparators, each with hysteresis, force the switch off. The first is a hard shutdown that acts at any time. The second is a fold-back threshold that acts only while the current limit is active. Fault sources follow a fixed priority: undervoltage, then thermal, then reverse voltage, then enable, then the duty-cycle timer.

Top module: `lsw_guard_ctrl`

## Requirements
- R1: State codes are OFF=0, UVLO_REARM=1, ON=2, REG_ON=3, REG_OFF=4, THERMAL_OFF=5. While reset is held and just after it, the state is UVLO_REARM and `sw_on` is 0. `sw_on` is 1 only in ON and REG_ON.
- R2: When `uv_low` is high, the state at the next clock edge is UVLO_REARM, whatever the other inputs are.
- R3: Once `uv_low` is low, the state stays UVLO_REARM until the edge that samples the 12th tick. On that edge it leaves according to the remaining inputs.
- R4: With no higher-priority fault, `en_n`=1 moves the state to OFF at the next edge. From OFF or THERMAL_OFF, `en_n`=0 moves it to ON, even when `ilim_act` is high, so toggling the enable clears the duty cycle.
- R5: In ON, `ilim_act`=1 moves the state to REG_ON at the next edge, and the switch stays on.
- R6: In REG_ON with `ilim_act` held, the state moves to REG_OFF on the edge that samples the 2nd tick after entry. If `ilim_act` falls first, the state returns to ON.
- R7: REG_OFF keeps the switch off until the edge that samples the 24th tick after entry, and then re-enters REG_ON.
- R8: While `rev_det` is high, with no undervoltage or thermal fault, the state is OFF. When `rev_det` falls with the enable low, the state returns to ON.
- R9: A temperature above 140 moves the state to THERMAL_OFF. It stays there while the temperature is 120 or more, and releases at 119 or below. A temperature of exactly 140 does not trip it.
- R10: With `ilim_act` high, a temperature of 125 or more moves the state to THERMAL_OFF, and 124 does not. Once tripped, it holds while the temperature is above 115, even with `ilim_act` low, and releases at 115.
- R11: Thermal faults outrank reverse voltage, and undervoltage outranks thermal faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Channel enable, active low |
| uv_low | input | 1 | Supply below the undervoltage threshold |
| rev_det | input | 1 | Output voltage above input voltage |
| ilim_act | input | 1 | Analog current limiter is regulating |
| die_temp | input | 8 | Die temperature, degrees Celsius, unsigned |
| tick_ms | input | 1 | One-clock pulse every millisecond |
| sw_on | output | 1 | Power path may conduct |
| state_code | output | 3 | Controller state (encoding in R1) |

## Verification
Every decision is registered in one state register, and `sw_on` is decoded from it. A wrong transition therefore shows on `state_code` and `sw_on` at the edge right after the input change that should have caused it. The timing faults are different. A window counter that is off by one, or that is not cleared on entry, shows only at the edge of the 2nd, 12th or 24th tick. The tests count ticks one by one and check the state just before and just at each boundary. A thermal hysteresis flag that is stuck or never set shows only when the temperature crosses the release point. For that reason each threshold is tested from both sides: one degree inside the band and one degree past the release point.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  localparam int TEMP_W = 8;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_REARM   = 3'd1,
    ST_ON      = 3'd2,
    ST_REG_ON  = 3'd3,
    ST_REG_OFF = 3'd4,
    ST_HOT     = 3'd5
  } gate_st_e;

  // A window of len ticks expires on the edge that samples its len-th tick;
  // cnt holds the ticks already sampled since entry.
  function automatic logic window_done(int cnt, logic tick, int len);
    return tick && ((cnt + 1) >= len);
  endfunction

  // Hard shutdown: trips above trip, holds down to trip-hyst inclusive.
  function automatic logic tsd_next(int temp, logic prev, int trip, int hyst);
    return (temp > trip) || (prev && ((temp + hyst) >= trip));
  endfunction

  // Fold-back: trips at trip only while limiting, holds while above rel.
  function automatic logic fold_next(int temp, logic prev, logic ilim,
                                     int trip, int rel);
    return (ilim && (temp >= trip)) || (prev && (temp > rel));
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lsw_ms_timer.sv
module lsw_ms_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (tick && !at_max) cnt <= cnt + 1'b1;
  end

  // R3: the window counter saturates instead of wrapping to zero
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/lsw_thermal_mon.sv
module lsw_thermal_mon
  import lsw_pkg::*;
#(
  parameter int TSD_TRIP  = 140,
  parameter int TSD_HYST  = 20,
  parameter int FOLD_TRIP = 125,
  parameter int FOLD_REL  = 115
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic              ilim_act,
  output logic              tsd_act,
  output logic              fold_act
);

  localparam int TSD_REL = TSD_TRIP - TSD_HYST;

  logic tsd_q;
  logic fold_q;

  assign tsd_act  = tsd_next(int'(die_temp), tsd_q, TSD_TRIP, TSD_HYST);
  assign fold_act = fold_next(int'(die_temp), fold_q, ilim_act,
                              FOLD_TRIP, FOLD_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsd_q  <= 1'b0;
      fold_q <= 1'b0;
    end else begin
      tsd_q  <= tsd_act;
      fold_q <= fold_act;
    end
  end

  // R9: an armed shutdown stays armed inside the hysteresis band
  p_tsd_band_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_q && (int'(die_temp) >= TSD_REL)) |-> tsd_act);

  // R10: fold-back releases once the temperature reaches the release point
  p_fold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ilim_act && (int'(die_temp) <= FOLD_REL)) |-> !fold_act);

endmodule

// File: rtl/lsw_gate_fsm.sv
module lsw_gate_fsm
  import lsw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     uv_low,
  input  logic     en_n,
  input  logic     rev_det,
  input  logic     ilim_act,
  input  logic     therm_trip,
  input  logic     rearm_done,
  input  logic     on_done,
  input  logic     off_done,
  output gate_st_e st,
  output logic     tmr_clr
);

  gate_st_e nxt;
  logic     fault_free;

  assign fault_free = !therm_trip && !rev_det && !en_n;

  always_comb begin
    nxt = st;
    if (uv_low)                          nxt = ST_REARM;
    else if (st == ST_REARM && !rearm_done) nxt = ST_REARM;
    else if (therm_trip)                 nxt = ST_HOT;
    else if (rev_det)                    nxt = ST_OFF;
    else if (en_n)                       nxt = ST_OFF;
    else begin
      unique case (st)
        ST_ON:      nxt = ilim_act ? ST_REG_ON : ST_ON;
        ST_REG_ON:  nxt = !ilim_act ? ST_ON : (on_done ? ST_REG_OFF : ST_REG_ON);
        ST_REG_OFF: nxt = off_done ? ST_REG_ON : ST_REG_OFF;
        default:    nxt = ST_ON;
      endcase
    end
  end

  // every window restarts on entry; undervoltage holds the re-arm window at zero
  assign tmr_clr = (nxt != st) || uv_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_REARM;
    else        st <= nxt;
  end

  // R2: undervoltage wins over every other input
  p_uv_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_low |=> (st == ST_REARM));

  // R3: no exit from re-arm before the window expires
  p_rearm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REARM && !rearm_done) |=> (st == ST_REARM));

  // R4: a disable with no higher fault lands in OFF
  p_disable_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_REARM && !uv_low && !therm_trip && !rev_det && en_n)
      |=> (st == ST_OFF));

  // R5: current limit in ON enters the regulated-on window
  p_enter_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && !uv_low && fault_free && ilim_act) |=> (st == ST_REG_ON));

  // R7: cool-down window is not cut short
  p_cool_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REG_OFF && !uv_low && fault_free && !off_done)
      |=> (st == ST_REG_OFF));

  // R8: reverse voltage below thermal priority forces OFF
  p_reverse_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_REARM && !uv_low && !therm_trip && rev_det) |=> (st == ST_OFF));

endmodule

// File: rtl/lsw_guard_ctrl.sv
module lsw_guard_ctrl
  import lsw_pkg::*;
#(
  parameter int REARM_MS    = 12,
  parameter int REG_ON_MS   = 2,
  parameter int REG_OFF_MS  = 24,
  parameter int TSD_TRIP_C  = 140,
  parameter int TSD_HYST_C  = 20,
  parameter int FOLD_TRIP_C = 125,
  parameter int FOLD_REL_C  = 115
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              uv_low,
  input  logic              rev_det,
  input  logic              ilim_act,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic              tick_ms,
  output logic              sw_on,
  output logic [2:0]        state_code
);

  localparam int MAX_WIN = max3(REARM_MS, REG_ON_MS, REG_OFF_MS);
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  gate_st_e         st;
  logic [CNT_W-1:0] win_cnt;
  logic             tmr_clr;
  logic             tsd_act;
  logic             fold_act;
  logic             therm_trip;
  logic             rearm_done;
  logic             on_done;
  logic             off_done;

  lsw_thermal_mon #(
    .TSD_TRIP  (TSD_TRIP_C),
    .TSD_HYST  (TSD_HYST_C),
    .FOLD_TRIP (FOLD_TRIP_C),
    .FOLD_REL  (FOLD_REL_C)
  ) u_therm (
    .clk      (clk),
    .rst_n    (rst_n),
    .die_temp (die_temp),
    .ilim_act (ilim_act),
    .tsd_act  (tsd_act),
    .fold_act (fold_act)
  );

  assign therm_trip = tsd_act || fold_act;

  lsw_ms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (tick_ms),
    .cnt   (win_cnt)
  );

  assign rearm_done = window_done(int'(win_cnt), tick_ms, REARM_MS);
  assign on_done    = window_done(int'(win_cnt), tick_ms, REG_ON_MS);
  assign off_done   = window_done(int'(win_cnt), tick_ms, REG_OFF_MS);

  lsw_gate_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .uv_low     (uv_low),
    .en_n       (en_n),
    .rev_det    (rev_det),
    .ilim_act   (ilim_act),
    .therm_trip (therm_trip),
    .rearm_done (rearm_done),
    .on_done    (on_done),
    .off_done   (off_done),
    .st         (st),
    .tmr_clr    (tmr_clr)
  );

  assign sw_on      = (st == ST_ON) || (st == ST_REG_ON);
  assign state_code = st;

  // R9: a hot die outside re-arm is shut down at the next edge
  p_tsd_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_low && st != ST_REARM && int'(die_temp) > TSD_TRIP_C)
      |=> (state_code == 3'd5 && !sw_on));

  // R10: fold-back under current limit switches the path off
  p_fold_trip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_low && st != ST_REARM && ilim_act && int'(die_temp) >= FOLD_TRIP_C)
      |=> !sw_on);

  // R11: thermal outranks reverse voltage
  p_therm_over_rev_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_low && st != ST_REARM && therm_trip && rev_det) |=> (state_code == 3'd5));

endmodule

// File: tb/test_lsw_guard_ctrl.sv
`timescale 1ns/1ps
module test_lsw_guard_ctrl;

  localparam logic [2:0] C_OFF = 3'd0, C_REARM = 3'd1, C_ON = 3'd2,
                         C_RON = 3'd3, C_ROFF = 3'd4, C_HOT = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n, en_n, uv_low, rev_det, ilim_act, tick_ms;
  logic [7:0] die_temp;
  logic       sw_on;
  logic [2:0] state_code;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  lsw_guard_ctrl i_lsw_guard_ctrl (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_low(uv_low), .rev_det(rev_det),
    .ilim_act(ilim_act), .die_temp(die_temp), .tick_ms(tick_ms),
    .sw_on(sw_on), .state_code(state_code)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; step(); tick_ms = 1'b0;
    end
  endtask

  task automatic expect_st(string req, logic [2:0] st);
    logic exp_sw;
    exp_sw = (st == C_ON) || (st == C_RON);
    n_chk++;
    if (state_code !== st || sw_on !== exp_sw) begin
      n_fail++;
      $display("FAIL %s: state=%0d sw_on=%0b expected state=%0d sw_on=%0b",
               req, state_code, sw_on, st, exp_sw);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic t_reset_r1();
    rst_n = 0; en_n = 1; uv_low = 0; rev_det = 0; ilim_act = 0;
    tick_ms = 0; die_temp = 8'd25;
    step(2);
    expect_st("R1 in reset", C_REARM);
    rst_n = 1; step();
    expect_st("R1 after reset", C_REARM);
  endtask

  task automatic t_rearm_r3();
    ticks(11);
    expect_st("R3 11 ticks", C_REARM);
    ticks(1);
    expect_st("R3 12th tick exits to OFF", C_OFF);
  endtask

  task automatic t_enable_r4();
    en_n = 0; step();
    expect_st("R4 enable", C_ON);
    en_n = 1; step();
    expect_st("R4 disable", C_OFF);
    ilim_act = 1; en_n = 0; step();
    expect_st("R4 enable under limit starts ON", C_ON);
  endtask

  task automatic t_reg_loop_r5_r6_r7();
    step();
    expect_st("R5 limit in ON", C_RON);
    ticks(1);
    expect_st("R6 1st tick", C_RON);
    ticks(1);
    expect_st("R6 2nd tick to cool-down", C_ROFF);
    ticks(23);
    expect_st("R7 23 ticks", C_ROFF);
    ticks(1);
    expect_st("R7 24th tick back on", C_RON);
    ilim_act = 0; step();
    expect_st("R6 limit clears", C_ON);
    // toggle clears loop (R4)
    ilim_act = 1; step(); ticks(2);
    expect_st("R7 second cool-down", C_ROFF);
    en_n = 1; step();
    expect_st("R4 disable in cool-down", C_OFF);
    ilim_act = 0; en_n = 0; step();
    expect_st("R4 re-enable clears loop", C_ON);
  endtask

  task automatic t_reverse_r8();
    rev_det = 1; step();
    expect_st("R8 reverse off", C_OFF);
    step(3);
    expect_st("R8 reverse held", C_OFF);
    rev_det = 0; step();
    expect_st("R8 reverse cleared", C_ON);
  endtask

  task automatic t_tsd_r9();
    die_temp = 8'd140; step();
    expect_st("R9 140 no trip", C_ON);
    die_temp = 8'd141; step();
    expect_st("R9 141 trips", C_HOT);
    die_temp = 8'd120; step(2);
    expect_st("R9 120 holds", C_HOT);
    die_temp = 8'd119; step();
    expect_st("R9 119 releases", C_ON);
  endtask

  task automatic t_fold_r10();
    die_temp = 8'd130; step();
    expect_st("R10 no limit no trip", C_ON);
    die_temp = 8'd124; ilim_act = 1; step();
    expect_st("R10 124 under limit regulates", C_RON);
    die_temp = 8'd125; step();
    expect_st("R10 125 trips", C_HOT);
    ilim_act = 0; die_temp = 8'd116; step();
    expect_st("R10 116 holds", C_HOT);
    die_temp = 8'd115; step();
    expect_st("R10 115 releases", C_ON);
  endtask

  task automatic t_priority_r11_r2();
    die_temp = 8'd150; rev_det = 1; step();
    expect_st("R11 thermal over reverse", C_HOT);
    uv_low = 1; step();
    expect_st("R11 R2 uv over thermal", C_REARM);
    rev_det = 0; die_temp = 8'd25; ticks(20);
    expect_st("R2 ticks ignored under uv", C_REARM);
    uv_low = 0; ticks(11);
    expect_st("R3 re-arm 11 ticks", C_REARM);
    ticks(1);
    expect_st("R3 re-arm to ON", C_ON);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run expired expected completion");
    report();
    $finish;
  end

  initial begin
    t_reset_r1();
    t_rearm_r3();
    t_enable_r4();
    t_reg_loop_r5_r6_r7();
    t_reverse_r8();
    t_tsd_r9();
    t_fold_r10();
    t_priority_r11_r2();
    report();
    $finish;
  end

endmodule